// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block is a 32-bit integer operation slice that computes one of six operations on two operands and produces a result together with six status flags. The result is available in the same cycle as its inputs. The flags are held in a register that captures the status of the current operation only when an update strobe is high at a rising clock edge. While the strobe is low, the register keeps the status of the last operation that was loaded.

The flags describe the result. Carry and overflow report an unsigned or signed range failure. Sign copies the top result bit. Zero flags an all-zero result. Auxiliary carry reports a carry or borrow across the boundary between the low two nibbles. Parity reports whether the lowest result byte holds an even number of ones. A flag is set when it reads 1 and clear when it reads 0.

Top module: `flag_alu`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released until the first update, all six flag outputs read 0.
- R2: The result is combinational and wraps modulo 2^W. Opcode 0 gives A+B, 1 gives A-B, 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, 5 gives NOT A, and 6 or 7 give zero.
- R3: For add, carry is the carry out of the top bit. For subtract, carry is set exactly when A < B unsigned, which is a borrow.
- R4: For add and subtract, overflow is set exactly when the true two's-complement result lies outside the signed range of W bits.
- R5: Sign equals the most significant bit of the result.
- R6: Zero is set exactly when all W result bits are 0.
- R7: For add, auxiliary carry is set when A[3:0]+B[3:0] exceeds 15. For subtract, it is set when A[3:0] < B[3:0].
- R8: Parity is set exactly when result bits [7:0] hold an even number of ones.
- R9: Opcodes 2 through 7 clear carry, overflow and auxiliary carry, and still set sign, zero and parity from their result.
- R10: The flags load the status of the inputs present at a rising edge only when `upd_i` is high at that edge. Otherwise they hold their value, whatever the operands and opcode do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select (see R2) |
| a_i | input | W (32) | First operand |
| b_i | input | W (32) | Second operand |
| upd_i | input | 1 | Flag register load strobe |
| res_o | output | W (32) | Combinational result |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| af_o | output | 1 | Auxiliary carry flag |
| pf_o | output | 1 | Parity flag |

## Verification
Directed cases aim at the edges of each flag, and each targets a specific fault:
- An all-ones plus one add wraps to zero. A design that dropped the carry-out or evaluated zero on the wrong width would miss it.
- Positive-limit addition and negative-limit subtraction expose overflow logic that compares the wrong sign bits or forgets the inverted subtrahend.
- Subtracting a larger value from a smaller one exposes a carry that reports the raw adder carry instead of the borrow.
- Nibble borrows such as 0x10 minus 1 catch an auxiliary flag with the wrong polarity on subtract.
- Results with many ones above bit 7 catch parity taken over the whole word.

Hold cycles with changing operands catch a register that ignores the strobe. Random operations then compare every flag with a behavioural model on every clock.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_NOT  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } status_t;

    localparam int NIBBLE = 4;
    localparam int PAR_BITS = 8;

endpackage

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           cf_raw,
    output logic           of_raw,
    output logic           af_raw
);
    localparam int MSB = W - 1;

    logic          is_sub;
    logic          is_arith;
    logic [W-1:0]  b_eff;
    logic [W:0]    sum_ext;
    logic [NIBBLE:0] nib_sum;

    always_comb begin
        is_sub   = (op == OP_SUB);
        is_arith = (op == OP_ADD) || (op == OP_SUB);
        b_eff    = is_sub ? ~b : b;
        sum_ext  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        nib_sum  = {1'b0, a[NIBBLE-1:0]} + {1'b0, b_eff[NIBBLE-1:0]}
                 + {{NIBBLE{1'b0}}, is_sub};

        unique case (op)
            OP_ADD, OP_SUB: res = sum_ext[W-1:0];
            OP_AND:         res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_NOT:         res = ~a;
            default:        res = '0;
        endcase

        cf_raw = is_arith & (sum_ext[W] ^ is_sub);
        of_raw = is_arith & (a[MSB] == b_eff[MSB]) & (sum_ext[MSB] != a[MSB]);
        af_raw = is_arith & (nib_sum[NIBBLE] ^ is_sub);
    end

endmodule

// File: rtl/flag_alu_flagreg.sv
module flag_alu_flagreg
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [W-1:0]  res,
    input  logic          cf_raw,
    input  logic          of_raw,
    input  logic          af_raw,
    output status_t       flags
);
    status_t flags_d;
    status_t flags_q;

    always_comb begin
        flags_d = flags_q;
        if (upd) begin
            flags_d.cf = cf_raw;
            flags_d.of = of_raw;
            flags_d.sf = res[W-1];
            flags_d.zf = (res == '0);
            flags_d.af = af_raw;
            flags_d.pf = ~(^res[PAR_BITS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags_q)); // R10
    AST_SIGN_TRACKS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> flags_q.sf == $past(res[W-1])); // R5
    AST_ZERO_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && res == '0) |=> flags_q.zf); // R6
    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && $countones(res[PAR_BITS-1:0]) == 0) |=> flags_q.pf); // R8

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          upd_i,
    output logic [W-1:0]  res_o,
    output logic          cf_o,
    output logic          of_o,
    output logic          sf_o,
    output logic          zf_o,
    output logic          af_o,
    output logic          pf_o
);
    alu_op_e  op_sel;
    logic     cf_raw;
    logic     of_raw;
    logic     af_raw;
    status_t  flags;

    assign op_sel = alu_op_e'(op_i);

    flag_alu_datapath #(.W(W)) u_datapath (
        .op     (op_sel),
        .a      (a_i),
        .b      (b_i),
        .res    (res_o),
        .cf_raw (cf_raw),
        .of_raw (of_raw),
        .af_raw (af_raw)
    );

    flag_alu_flagreg #(.W(W)) u_flagreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd_i),
        .res    (res_o),
        .cf_raw (cf_raw),
        .of_raw (of_raw),
        .af_raw (af_raw),
        .flags  (flags)
    );

    assign cf_o = flags.cf;
    assign of_o = flags.of;
    assign sf_o = flags.sf;
    assign zf_o = flags.zf;
    assign af_o = flags.af;
    assign pf_o = flags.pf;

    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i >= 3'd2) |=> (!cf_o && !of_o && !af_o)); // R9
    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && op_i == 3'd1) |=> cf_o == $past(a_i < b_i)); // R3

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_i = '0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic          upd_i = 1'b0;
    logic [W-1:0]  res_o;
    logic          cf_o, of_o, sf_o, zf_o, af_o, pf_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    flag_alu #(.W(W)) u_flag_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .upd_i(upd_i), .res_o(res_o), .cf_o(cf_o), .of_o(of_o),
        .sf_o(sf_o), .zf_o(zf_o), .af_o(af_o), .pf_o(pf_o)
    );

    // reference: {res[31:0], cf, of, sf, zf, af, pf}
    function automatic logic [37:0] ref_calc(input int op, input logic [31:0] a, input logic [31:0] b);
        longint ua, ub, sa, sb, ss, us;
        logic [31:0] r;
        logic cf, of, af;
        int ones;
        ua = longint'({32'd0, a});
        ub = longint'({32'd0, b});
        sa = longint'(signed'(a));
        sb = longint'(signed'(b));
        cf = 0; of = 0; af = 0;
        case (op)
            0: begin
                us = ua + ub; r = us[31:0];
                cf = us > 64'sd4294967295;
                ss = sa + sb;
                of = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
                af = ((ua % 16) + (ub % 16)) > 15;
            end
            1: begin
                us = ua - ub; r = us[31:0];
                cf = ua < ub;
                ss = sa - sb;
                of = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
                af = (ua % 16) < (ub % 16);
            end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = ~a;
            default: r = 32'd0;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) if (r[i]) ones++;
        return {r, cf, of, r[31], (r == 32'd0), af, (ones % 2 == 0)};
    endfunction

    // behavioural flag model
    logic [5:0] exp_flags = '0;
    logic       last_upd = 1'b0;
    logic       last_logic = 1'b0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_flags <= '0;
            last_upd <= 1'b0;
            last_logic <= 1'b0;
        end else begin
            logic [37:0] v;
            v = ref_calc(int'(op_i), a_i, b_i);
            last_upd <= upd_i;
            if (upd_i) begin
                exp_flags <= v[5:0];
                last_logic <= (op_i >= 3'd2);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (op=%0d a=%h b=%h)", tag, act, exp, op_i, a_i, b_i);
        end
    endtask

    task automatic check_all();
        logic [37:0] v;
        v = ref_calc(int'(op_i), a_i, b_i);
        chk("R2 result", res_o, v[37:6]);
        if (!last_upd) begin
            chk("R10 hold flags", {26'd0, cf_o, of_o, sf_o, zf_o, af_o, pf_o}, {26'd0, exp_flags});
        end else begin
            chk(last_logic ? "R9 carry" : "R3 carry", {31'd0, cf_o}, {31'd0, exp_flags[5]});
            chk(last_logic ? "R9 overflow" : "R4 overflow", {31'd0, of_o}, {31'd0, exp_flags[4]});
            chk("R5 sign", {31'd0, sf_o}, {31'd0, exp_flags[3]});
            chk("R6 zero", {31'd0, zf_o}, {31'd0, exp_flags[2]});
            chk(last_logic ? "R9 aux" : "R7 aux", {31'd0, af_o}, {31'd0, exp_flags[1]});
            chk("R8 parity", {31'd0, pf_o}, {31'd0, exp_flags[0]});
        end
    endtask

    task automatic step(input int op, input logic [31:0] a, input logic [31:0] b, input logic u);
        op_i = 3'(op); a_i = a; b_i = b; upd_i = u;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: flags zero in reset, even with an update request and operands that would set flags
        op_i = 3'd0; a_i = 32'hFFFFFFFF; b_i = 32'h1; upd_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset flags", {26'd0, cf_o, of_o, sf_o, zf_o, af_o, pf_o}, 32'd0);
        upd_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset flags", {26'd0, cf_o, of_o, sf_o, zf_o, af_o, pf_o}, 32'd0);

        // R3/R6/R7/R8: wrap to zero
        step(0, 32'hFFFFFFFF, 32'h00000001, 1'b1);
        // R4/R5: positive overflow
        step(0, 32'h7FFFFFFF, 32'h00000001, 1'b1);
        // R3: borrow
        step(1, 32'h00000000, 32'h00000001, 1'b1);
        // R4: negative limit minus one
        step(1, 32'h80000000, 32'h00000001, 1'b1);
        // R7: nibble borrow
        step(1, 32'h00000010, 32'h00000001, 1'b1);
        step(1, 32'h12345678, 32'h12345678, 1'b1);
        // R8: many ones above the low byte
        step(0, 32'hFFFFFF00, 32'h00000003, 1'b1);
        // R9: logical ops after a carry-setting add
        step(0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        step(2, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1);
        step(0, 32'h8000000F, 32'h80000001, 1'b1);
        step(3, 32'h80000000, 32'h00000001, 1'b1);
        step(4, 32'hA5A5A5A5, 32'hFFFFFFFF, 1'b1);
        step(5, 32'h00000000, 32'h12345678, 1'b1);
        step(6, 32'hDEADBEEF, 32'h12345678, 1'b1);
        step(7, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
        // R10: hold while operands change
        step(0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1);
        step(0, 32'h00000000, 32'h00000000, 1'b0);
        step(1, 32'h00000000, 32'hFFFFFFFF, 1'b0);
        step(2, 32'h00000000, 32'h00000000, 1'b0);
        step(1, 32'h00000005, 32'h00000003, 1'b1);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (n % 7 == 0) rb = ra;
            if (n % 11 == 0) ra = 32'h80000000 ^ (ra & 32'hF);
            step(int'($urandom % 8), ra, rb, ($urandom % 4) != 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule